// File: doc/BRIEF.md
# Register Bank Read/Write Arbiter

This block decides, cycle by cycle, which access each bank of a multi-bank register file performs. Two kinds of traffic compete for the banks. Writeback traffic names up to `NUM_WR` destination registers for one thread and must never be held back. Operand reads come from `NUM_CU` collector units: when a collector is allocated an instruction, each of its valid source operands becomes a read request. The request is placed in the queue of the bank that its register lives in. The register storage and the data paths sit outside this block. It only produces, for every bank, a registered grant record: free, read (with the collector id and operand index served), or write.

The bank of a register is derived from the register number and the warp the thread belongs to, so that the same register of different warps spreads over the banks. In every cycle the arbiter first reserves the banks hit by writeback. It then lets each collector claim at most one of the remaining banks whose queue head belongs to it. Each collector scans the banks in round-robin order from its own pointer. A granted request leaves its queue. When any queue could overflow on a worst-case allocation, the block stops accepting new collector allocations.

The per-bank allocation is a three-state machine: `BANK_FREE`, `BANK_READ` and `BANK_WRITE`. Every cycle each bank's next state is chosen afresh, starting from `BANK_FREE`. The transition `reserve` (a writeback hits the bank) leads to `BANK_WRITE`. The transition `grant` (a collector picked the bank's queue head) leads to `BANK_READ`. The transition `release` (neither happened) leads to `BANK_FREE`. No state persists past one cycle.

Top module: `rba_arbiter_top`

## Requirements
- R1: The bank of a request is (register number + thread id / WARP_SIZE) mod NUM_BANKS, for reads using `alloc_tid` and for writeback using `wb_tid`.
- R2: An accepted allocation appends every operand whose `alloc_op_vld` bit is set to its bank's queue, lower operand index first; such an entry can be granted no earlier than the cycle after the allocation.
- R3: A bank named by any valid writeback register in a cycle reports `BANK_WRITE` after the next clock edge and receives no read grant for that cycle; its queue head stays queued.
- R4: `bank_state[2b+1:2b]` encodes bank b as 0 = free, 1 = read, 2 = write; the value 3 never appears, and `rd_vld[b]` is high exactly when bank b reports read, so each bank performs at most one access per cycle.
- R5: A read grant for bank b appears one clock edge after the arbitration cycle, with `rd_cu` and `rd_op` set to the collector id and operand index at the head of that queue; the granted entry is removed.
- R6: A collector receives at most one read grant per cycle; it takes the first eligible bank at or after its pointer. The pointer starts at collector index mod NUM_BANKS and moves to the granted bank + 1 mod NUM_BANKS.
- R7: Grant records do not persist: a bank with no writeback and no grant in a cycle reports free after the next edge.
- R8: `alloc_ready` is low while any queue holds more than Q_DEPTH - NUM_OPS entries; an allocation offered while it is low changes no queue.
- R9: After reset all queues are empty, all banks report free, `rd_vld` is zero and `alloc_ready` is high.
- R10: Within one bank, requests are granted in the order they were queued, across collectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | A collector is being allocated this cycle |
| alloc_cu | input | CU_W | Id of the collector being allocated |
| alloc_tid | input | TID_W | Thread id of the first valid thread |
| alloc_op_vld | input | NUM_OPS | Per source operand: register present |
| alloc_regs | input | NUM_OPS*REG_W | Source register numbers, operand i at [i*REG_W +: REG_W] |
| alloc_ready | output | 1 | Queues can take a worst-case allocation |
| wb_valid | input | 1 | Writeback present this cycle |
| wb_tid | input | TID_W | Thread id of the writeback |
| wb_reg_vld | input | NUM_WR | Per destination: register present |
| wb_regs | input | NUM_WR*REG_W | Destination register numbers |
| bank_state | output | 2*NUM_BANKS | Registered per-bank grant record |
| rd_vld | output | NUM_BANKS | Registered read grant strobe per bank |
| rd_cu | output | NUM_BANKS*CU_W | Collector id of each read grant |
| rd_op | output | NUM_BANKS*OP_W | Operand index of each read grant |

## Verification
A writeback reservation and a read grant can fall on the same bank in the same cycle. The bench provokes this by queuing reads whose heads sit on known banks and then driving writeback registers that map to those banks, with both a different and the same warp offset. It judges that the bank reports write, that no read appears on it, and that the same queued head is granted in a later cycle once the writeback is gone. A second collision, an allocation offered while the queues are too full, is provoked by holding writeback on a bank so its queue cannot drain. It is judged by the later grant sequence, which must hold no entry from the refused allocation.

// File: rtl/rba_pkg.sv
package rba_pkg;

    // Per-bank allocation record, also the encoding of bank_state.
    typedef enum logic [1:0] {
        BANK_FREE  = 2'd0,
        BANK_READ  = 2'd1,
        BANK_WRITE = 2'd2
    } bank_alloc_e;

endpackage

// File: rtl/rba_bank_queue.sv
// Request queue of one bank. Several entries may be appended in one cycle
// (one per operand slot); at most one leaves from the head per cycle.
module rba_bank_queue #(
    parameter int NUM_CU  = 4,
    parameter int NUM_OPS = 4,
    parameter int Q_DEPTH = 8
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [NUM_OPS-1:0]                        push_mask,
    input  logic [(NUM_CU > 1 ? $clog2(NUM_CU) : 1)-1:0] push_cu,
    input  logic                                      pop,
    output logic                                      head_vld,
    output logic [(NUM_CU > 1 ? $clog2(NUM_CU) : 1)-1:0] head_cu,
    output logic [(NUM_OPS > 1 ? $clog2(NUM_OPS) : 1)-1:0] head_op,
    output logic [$clog2(Q_DEPTH+1)-1:0]              count
);

    localparam int CU_W  = NUM_CU > 1 ? $clog2(NUM_CU) : 1;
    localparam int OP_W  = NUM_OPS > 1 ? $clog2(NUM_OPS) : 1;
    localparam int CNT_W = $clog2(Q_DEPTH + 1);
    localparam int PTR_W = Q_DEPTH > 1 ? $clog2(Q_DEPTH) : 1;

    logic [CU_W-1:0]  ent_cu [Q_DEPTH];
    logic [OP_W-1:0]  ent_op [Q_DEPTH];
    logic [PTR_W-1:0] head_ptr;
    logic [PTR_W-1:0] tail_ptr;
    logic [PTR_W-1:0] wr_slot [NUM_OPS];
    logic [PTR_W-1:0] slot_off;
    logic [CNT_W-1:0] push_n;

    assign tail_ptr = head_ptr + PTR_W'(count);
    assign head_vld = (count != '0);
    assign head_cu  = ent_cu[head_ptr];
    assign head_op  = ent_op[head_ptr];

    // Slot of each appended operand: packed after the current tail in
    // operand-index order.
    always_comb begin
        slot_off = '0;
        push_n   = '0;
        for (int i = 0; i < NUM_OPS; i++) begin
            wr_slot[i] = tail_ptr + slot_off;
            if (push_mask[i]) begin
                slot_off = slot_off + PTR_W'(1);
                push_n   = push_n + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_OPS; i++) begin
            if (push_mask[i]) begin
                ent_cu[wr_slot[i]] <= push_cu;
                ent_op[wr_slot[i]] <= OP_W'(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_ptr <= '0;
            count    <= '0;
        end else begin
            if (pop && head_vld) begin
                head_ptr <= head_ptr + PTR_W'(1);
            end
            count <= count - CNT_W'(pop && head_vld) + push_n;
        end
    end

endmodule

// File: rtl/rba_rr_picker.sv
// Round-robin bank picker of one collector: takes the first candidate bank
// at or after its pointer, then moves the pointer past the granted bank.
module rba_rr_picker #(
    parameter int NUM_BANKS = 4,
    parameter int CU_INDEX  = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] cand,
    output logic [NUM_BANKS-1:0] sel
);

    localparam int BANK_W = NUM_BANKS > 1 ? $clog2(NUM_BANKS) : 1;

    logic [BANK_W-1:0] rr_ptr;
    logic              found;
    int                hit;
    int                idx;

    always_comb begin
        sel   = '0;
        found = 1'b0;
        hit   = 0;
        idx   = 0;
        for (int k = 0; k < NUM_BANKS; k++) begin
            idx = (int'(rr_ptr) + k) % NUM_BANKS;
            if (!found && cand[idx]) begin
                found    = 1'b1;
                hit      = idx;
                sel[idx] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_ptr <= BANK_W'(CU_INDEX % NUM_BANKS);
        end else if (found) begin
            rr_ptr <= BANK_W'((hit + 1) % NUM_BANKS);
        end
    end

endmodule

// File: rtl/rba_arbiter_top.sv
module rba_arbiter_top
    import rba_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int NUM_CU    = 4,
    parameter int NUM_OPS   = 4,
    parameter int NUM_WR    = 2,
    parameter int REG_W     = 6,
    parameter int TID_W     = 10,
    parameter int WARP_SIZE = 32,
    parameter int Q_DEPTH   = 8,
    localparam int CU_W     = NUM_CU > 1 ? $clog2(NUM_CU) : 1,
    localparam int OP_W     = NUM_OPS > 1 ? $clog2(NUM_OPS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        alloc_valid,
    input  logic [CU_W-1:0]             alloc_cu,
    input  logic [TID_W-1:0]            alloc_tid,
    input  logic [NUM_OPS-1:0]          alloc_op_vld,
    input  logic [NUM_OPS*REG_W-1:0]    alloc_regs,
    output logic                        alloc_ready,
    input  logic                        wb_valid,
    input  logic [TID_W-1:0]            wb_tid,
    input  logic [NUM_WR-1:0]           wb_reg_vld,
    input  logic [NUM_WR*REG_W-1:0]     wb_regs,
    output logic [2*NUM_BANKS-1:0]      bank_state,
    output logic [NUM_BANKS-1:0]        rd_vld,
    output logic [NUM_BANKS*CU_W-1:0]   rd_cu,
    output logic [NUM_BANKS*OP_W-1:0]   rd_op
);

    localparam int BANK_W = NUM_BANKS > 1 ? $clog2(NUM_BANKS) : 1;
    localparam int CNT_W  = $clog2(Q_DEPTH + 1);
    localparam int SUM_W  = (TID_W > REG_W ? TID_W : REG_W) + 1;
    localparam int HEADROOM = Q_DEPTH - NUM_OPS;

    // ---------------- bank mapping ----------------
    logic [BANK_W-1:0] rd_bank [NUM_OPS];
    logic [BANK_W-1:0] wr_bank [NUM_WR];
    logic [SUM_W-1:0]  rd_sum  [NUM_OPS];
    logic [SUM_W-1:0]  wr_sum  [NUM_WR];

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_rd_map
        assign rd_sum[i]  = SUM_W'(alloc_regs[i*REG_W +: REG_W])
                          + SUM_W'(alloc_tid / TID_W'(WARP_SIZE));
        assign rd_bank[i] = BANK_W'(rd_sum[i] % SUM_W'(NUM_BANKS));
    end

    for (genvar i = 0; i < NUM_WR; i++) begin : g_wr_map
        assign wr_sum[i]  = SUM_W'(wb_regs[i*REG_W +: REG_W])
                          + SUM_W'(wb_tid / TID_W'(WARP_SIZE));
        assign wr_bank[i] = BANK_W'(wr_sum[i] % SUM_W'(NUM_BANKS));
    end

    // ---------------- write reservation ----------------
    logic [NUM_BANKS-1:0] wr_res;

    always_comb begin
        wr_res = '0;
        for (int i = 0; i < NUM_WR; i++) begin
            if (wb_valid && wb_reg_vld[i]) begin
                wr_res[wr_bank[i]] = 1'b1;
            end
        end
    end

    // ---------------- queues ----------------
    logic                 alloc_fire;
    logic [NUM_OPS-1:0]   push_mask [NUM_BANKS];
    logic [NUM_BANKS-1:0] q_vld;
    logic [CU_W-1:0]      q_cu     [NUM_BANKS];
    logic [OP_W-1:0]      q_op     [NUM_BANKS];
    logic [CNT_W-1:0]     q_count  [NUM_BANKS];
    logic [NUM_BANKS*CNT_W-1:0] q_count_flat;
    logic [NUM_BANKS-1:0] rd_pick;

    assign alloc_fire = alloc_valid && alloc_ready;

    always_comb begin
        alloc_ready = 1'b1;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (q_count[b] > CNT_W'(HEADROOM)) begin
                alloc_ready = 1'b0;
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar i = 0; i < NUM_OPS; i++) begin : g_mask
            assign push_mask[b][i] = alloc_fire && alloc_op_vld[i]
                                   && (rd_bank[i] == BANK_W'(b));
        end

        rba_bank_queue #(
            .NUM_CU  (NUM_CU),
            .NUM_OPS (NUM_OPS),
            .Q_DEPTH (Q_DEPTH)
        ) u_queue (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_mask (push_mask[b]),
            .push_cu   (alloc_cu),
            .pop       (rd_pick[b]),
            .head_vld  (q_vld[b]),
            .head_cu   (q_cu[b]),
            .head_op   (q_op[b]),
            .count     (q_count[b])
        );

        assign q_count_flat[b*CNT_W +: CNT_W] = q_count[b];
    end

    // ---------------- per-collector read pick ----------------
    logic [NUM_BANKS-1:0] cand [NUM_CU];
    logic [NUM_BANKS-1:0] sel  [NUM_CU];

    for (genvar c = 0; c < NUM_CU; c++) begin : g_cu
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cand
            assign cand[c][b] = q_vld[b] && !wr_res[b]
                              && (q_cu[b] == CU_W'(c));
        end

        rba_rr_picker #(
            .NUM_BANKS (NUM_BANKS),
            .CU_INDEX  (c)
        ) u_pick (
            .clk   (clk),
            .rst_n (rst_n),
            .cand  (cand[c]),
            .sel   (sel[c])
        );
    end

    always_comb begin
        rd_pick = '0;
        for (int c = 0; c < NUM_CU; c++) begin
            rd_pick = rd_pick | sel[c];
        end
    end

    // ---------------- per-bank allocation state ----------------
    bank_alloc_e st_next [NUM_BANKS];
    bank_alloc_e st_q    [NUM_BANKS];
    logic [CU_W-1:0] gcu_q [NUM_BANKS];
    logic [OP_W-1:0] gop_q [NUM_BANKS];

    // Next state: every bank restarts from free each cycle.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            unique case ({wr_res[b], rd_pick[b]})
                2'b10, 2'b11: st_next[b] = BANK_WRITE;
                2'b01:        st_next[b] = BANK_READ;
                default:      st_next[b] = BANK_FREE;
            endcase
        end
    end

    // State register with the read grant record.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                st_q[b]  <= BANK_FREE;
                gcu_q[b] <= '0;
                gop_q[b] <= '0;
            end
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                st_q[b] <= st_next[b];
                if (rd_pick[b]) begin
                    gcu_q[b] <= q_cu[b];
                    gop_q[b] <= q_op[b];
                end
            end
        end
    end

    // Outputs.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            bank_state[2*b +: 2]   = st_q[b];
            rd_vld[b]              = (st_q[b] == BANK_READ);
            rd_cu[b*CU_W +: CU_W]  = (st_q[b] == BANK_READ) ? gcu_q[b] : '0;
            rd_op[b*OP_W +: OP_W]  = (st_q[b] == BANK_READ) ? gop_q[b] : '0;
        end
    end

endmodule

// File: rtl/rba_checker.sv
module rba_checker #(
    parameter int NUM_BANKS = 4,
    parameter int NUM_CU    = 4,
    parameter int NUM_OPS   = 4,
    parameter int NUM_WR    = 2,
    parameter int REG_W     = 6,
    parameter int TID_W     = 10,
    parameter int WARP_SIZE = 32,
    parameter int Q_DEPTH   = 8
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   alloc_valid,
    input logic                                   alloc_ready,
    input logic                                   wb_valid,
    input logic [TID_W-1:0]                       wb_tid,
    input logic [NUM_WR-1:0]                      wb_reg_vld,
    input logic [NUM_WR*REG_W-1:0]                wb_regs,
    input logic [2*NUM_BANKS-1:0]                 bank_state,
    input logic [NUM_BANKS-1:0]                   rd_vld,
    input logic [NUM_BANKS*(NUM_CU > 1 ? $clog2(NUM_CU) : 1)-1:0] rd_cu,
    input logic [NUM_BANKS*$clog2(Q_DEPTH+1)-1:0] q_count_flat
);

    localparam int CU_W  = NUM_CU > 1 ? $clog2(NUM_CU) : 1;
    localparam int CNT_W = $clog2(Q_DEPTH + 1);

    logic [NUM_BANKS-1:0] wb_hit;
    logic [NUM_BANKS-1:0] cu_grants [NUM_CU];

    always_comb begin
        wb_hit = '0;
        for (int i = 0; i < NUM_WR; i++) begin
            if (wb_valid && wb_reg_vld[i]) begin
                wb_hit[(int'(wb_regs[i*REG_W +: REG_W])
                        + int'(wb_tid) / WARP_SIZE) % NUM_BANKS] = 1'b1;
            end
        end
        for (int c = 0; c < NUM_CU; c++) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                cu_grants[c][b] = rd_vld[b]
                                && (rd_cu[b*CU_W +: CU_W] == CU_W'(c));
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
        p_wb_reserve_r3: assert property (@(posedge clk) disable iff (!rst_n)
            wb_hit[b] |=> (bank_state[2*b +: 2] == 2'd2 && !rd_vld[b]));

        p_legal_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_state[2*b +: 2] != 2'd3)
            && (rd_vld[b] == (bank_state[2*b +: 2] == 2'd1)));

        p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
            q_count_flat[b*CNT_W +: CNT_W] <= CNT_W'(Q_DEPTH));

        p_stall_no_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (alloc_valid && !alloc_ready)
            |=> q_count_flat[b*CNT_W +: CNT_W]
                <= $past(q_count_flat[b*CNT_W +: CNT_W]));

        p_no_wb_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !wb_hit[b] |=> (bank_state[2*b +: 2] != 2'd2));
    end

    for (genvar c = 0; c < NUM_CU; c++) begin : g_cu_chk
        p_one_grant_per_cu_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(cu_grants[c]) <= 1);
    end

endmodule

bind rba_arbiter_top rba_checker #(
    .NUM_BANKS (NUM_BANKS),
    .NUM_CU    (NUM_CU),
    .NUM_OPS   (NUM_OPS),
    .NUM_WR    (NUM_WR),
    .REG_W     (REG_W),
    .TID_W     (TID_W),
    .WARP_SIZE (WARP_SIZE),
    .Q_DEPTH   (Q_DEPTH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_valid  (alloc_valid),
    .alloc_ready  (alloc_ready),
    .wb_valid     (wb_valid),
    .wb_tid       (wb_tid),
    .wb_reg_vld   (wb_reg_vld),
    .wb_regs      (wb_regs),
    .bank_state   (bank_state),
    .rd_vld       (rd_vld),
    .rd_cu        (rd_cu),
    .q_count_flat (q_count_flat)
);

// File: tb/rba_arbiter_top_tb.sv
`timescale 1ns/1ps
module rba_arbiter_top_tb;

    localparam int NB  = 4;
    localparam int NCU = 4;
    localparam int NOP = 4;
    localparam int NWR = 2;
    localparam int RW  = 4;
    localparam int TW  = 6;
    localparam int WS  = 4;
    localparam int QD  = 8;
    localparam int CW  = 2;
    localparam int OW  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_valid = 1'b0;
    logic [CW-1:0]     alloc_cu = '0;
    logic [TW-1:0]     alloc_tid = '0;
    logic [NOP-1:0]    alloc_op_vld = '0;
    logic [NOP*RW-1:0] alloc_regs = '0;
    logic              alloc_ready;
    logic              wb_valid = 1'b0;
    logic [TW-1:0]     wb_tid = '0;
    logic [NWR-1:0]    wb_reg_vld = '0;
    logic [NWR*RW-1:0] wb_regs = '0;
    logic [2*NB-1:0]   bank_state;
    logic [NB-1:0]     rd_vld;
    logic [NB*CW-1:0]  rd_cu;
    logic [NB*OW-1:0]  rd_op;

    rba_arbiter_top #(
        .NUM_BANKS(NB), .NUM_CU(NCU), .NUM_OPS(NOP), .NUM_WR(NWR),
        .REG_W(RW), .TID_W(TW), .WARP_SIZE(WS), .Q_DEPTH(QD)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_cu(alloc_cu), .alloc_tid(alloc_tid),
        .alloc_op_vld(alloc_op_vld), .alloc_regs(alloc_regs),
        .alloc_ready(alloc_ready),
        .wb_valid(wb_valid), .wb_tid(wb_tid), .wb_reg_vld(wb_reg_vld),
        .wb_regs(wb_regs),
        .bank_state(bank_state), .rd_vld(rd_vld), .rd_cu(rd_cu), .rd_op(rd_op)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string cur_req = "R9";

    // reference model state
    int mq_cu [NB][64];
    int mq_op [NB][64];
    int mhead [NB];
    int mcnt  [NB];
    int mptr  [NCU];

    // stimulus for the next cycle
    bit s_av;  int s_acu; int s_atid; bit [NOP-1:0] s_aov; int s_ar [NOP];
    bit s_wv;  int s_wtid; bit [NWR-1:0] s_wrv; int s_wr [NWR];

    function automatic int bmap(int r, int t);
        return (r + t / WS) % NB;
    endfunction

    task automatic check(bit ok, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int b = 0; b < NB; b++) begin mhead[b] = 0; mcnt[b] = 0; end
        for (int c = 0; c < NCU; c++) mptr[c] = c % NB;
    endtask

    task automatic clear_stim();
        s_av = 0; s_acu = 0; s_atid = 0; s_aov = '0;
        for (int i = 0; i < NOP; i++) s_ar[i] = 0;
        s_wv = 0; s_wtid = 0; s_wrv = '0;
        for (int i = 0; i < NWR; i++) s_wr[i] = 0;
    endtask

    // One cycle: drive, predict, clock, compare.
    task automatic step();
        int  exp_st [NB];
        int  exp_cu [NB];
        int  exp_op [NB];
        bit  wr [NB];
        bit  exp_ready;
        alloc_valid  = s_av;
        alloc_cu     = CW'(s_acu);
        alloc_tid    = TW'(s_atid);
        alloc_op_vld = s_aov;
        for (int i = 0; i < NOP; i++) alloc_regs[i*RW +: RW] = RW'(s_ar[i]);
        wb_valid   = s_wv;
        wb_tid     = TW'(s_wtid);
        wb_reg_vld = s_wrv;
        for (int i = 0; i < NWR; i++) wb_regs[i*RW +: RW] = RW'(s_wr[i]);
        #1;
        exp_ready = 1;
        for (int b = 0; b < NB; b++) if (mcnt[b] > QD - NOP) exp_ready = 0;
        check(alloc_ready == exp_ready, "alloc_ready (R8)", int'(alloc_ready), int'(exp_ready));
        for (int b = 0; b < NB; b++) begin
            wr[b] = 0; exp_st[b] = 0; exp_cu[b] = 0; exp_op[b] = 0;
        end
        if (s_wv) for (int i = 0; i < NWR; i++)
            if (s_wrv[i]) wr[bmap(s_wr[i], s_wtid)] = 1;
        for (int b = 0; b < NB; b++) if (wr[b]) exp_st[b] = 2;
        for (int c = 0; c < NCU; c++) begin
            bit got = 0;
            for (int k = 0; k < NB; k++) begin
                int b = (mptr[c] + k) % NB;
                if (!got && !wr[b] && mcnt[b] > 0 && mq_cu[b][mhead[b]] == c) begin
                    got = 1;
                    exp_st[b] = 1;
                    exp_cu[b] = c;
                    exp_op[b] = mq_op[b][mhead[b]];
                    mptr[c] = (b + 1) % NB;
                end
            end
        end
        for (int b = 0; b < NB; b++) if (exp_st[b] == 1) begin
            mhead[b] = (mhead[b] + 1) % 64; mcnt[b]--;
        end
        if (s_av && exp_ready) begin
            for (int i = 0; i < NOP; i++) if (s_aov[i]) begin
                int b = bmap(s_ar[i], s_atid);
                mq_cu[b][(mhead[b] + mcnt[b]) % 64] = s_acu;
                mq_op[b][(mhead[b] + mcnt[b]) % 64] = i;
                mcnt[b]++;
            end
        end
        @(posedge clk);
        #2;
        for (int b = 0; b < NB; b++) begin
            check(int'(bank_state[2*b +: 2]) == exp_st[b], $sformatf("bank %0d state", b),
                  int'(bank_state[2*b +: 2]), exp_st[b]);
            check(rd_vld[b] == (exp_st[b] == 1), $sformatf("bank %0d rd_vld", b),
                  int'(rd_vld[b]), int'(exp_st[b] == 1));
            if (exp_st[b] == 1) begin
                check(int'(rd_cu[b*CW +: CW]) == exp_cu[b], $sformatf("bank %0d cu", b),
                      int'(rd_cu[b*CW +: CW]), exp_cu[b]);
                check(int'(rd_op[b*OW +: OW]) == exp_op[b], $sformatf("bank %0d op", b),
                      int'(rd_op[b*OW +: OW]), exp_op[b]);
            end
        end
        clear_stim();
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    int lcg = 12345;
    function automatic int rnd(int m);
        lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
        return (lcg >>> 8) % m;
    endfunction

    initial begin
        clear_stim();
        model_reset();
        #21 rst_n = 1'b1;
        @(posedge clk); #2;

        // R9: reset state
        cur_req = "R9";
        check(bank_state == '0, "reset bank_state", int'(bank_state), 0);
        check(rd_vld == '0, "reset rd_vld", int'(rd_vld), 0);
        check(alloc_ready == 1'b1, "reset alloc_ready", int'(alloc_ready), 1);

        // R7: idle banks stay free
        cur_req = "R7";
        idle(3);

        // R1: bank mapping sweep, one operand per allocation
        cur_req = "R1";
        for (int t = 0; t < 64; t += 3) begin
            for (int r = 0; r < 16; r++) begin
                s_av = 1; s_acu = r % NCU; s_atid = t;
                s_aov = NOP'(1) << (r % NOP); s_ar[r % NOP] = r;
                step();
                step();
                check(rd_vld[bmap(r, t)] == 1'b1, "mapped bank granted",
                      int'(rd_vld), 1 << bmap(r, t));
            end
        end

        // R2 / R10: same-bank operands queue in order, across collectors
        cur_req = "R2";
        s_av = 1; s_acu = 1; s_atid = 0; s_aov = 4'b1111;
        s_ar[0] = 2; s_ar[1] = 6; s_ar[2] = 10; s_ar[3] = 14;
        step();
        cur_req = "R10";
        s_av = 1; s_acu = 2; s_atid = 0; s_aov = 4'b0101;
        s_ar[0] = 3; s_ar[2] = 7;
        step();
        idle(8);

        // R6: one grant per collector per cycle, round-robin from pointer
        cur_req = "R6";
        for (int c = 0; c < NCU; c++) begin
            s_av = 1; s_acu = c; s_atid = 4 * c; s_aov = 4'b1111;
            s_ar[0] = 0; s_ar[1] = 1; s_ar[2] = 2; s_ar[3] = 3;
            step();
            idle(5);
        end

        // R3: writeback and read collide on the same bank
        cur_req = "R3";
        s_av = 1; s_acu = 0; s_atid = 0; s_aov = 4'b0011; s_ar[0] = 0; s_ar[1] = 1;
        step();
        s_wv = 1; s_wtid = 4; s_wrv = 2'b11; s_wr[0] = 3; s_wr[1] = 0; // banks 0 and 1
        step();
        s_wv = 1; s_wtid = 0; s_wrv = 2'b01; s_wr[0] = 1;
        step();
        idle(3);

        // R8: fill bank 0 while writeback holds it, then offer a refused allocation
        cur_req = "R8";
        for (int k = 0; k < 3; k++) begin
            s_av = 1; s_acu = 3; s_atid = 0; s_aov = 4'b1111;
            for (int i = 0; i < NOP; i++) s_ar[i] = 4 * i;
            s_wv = 1; s_wtid = 0; s_wrv = 2'b01; s_wr[0] = 0;
            step();
        end
        check(alloc_ready == 1'b0, "ready low when queue deep", int'(alloc_ready), 0);
        idle(12);

        // R4 / R5: mixed traffic
        cur_req = "R5";
        for (int n = 0; n < 4000; n++) begin
            if (rnd(3) != 0) begin
                s_av = 1; s_acu = rnd(NCU); s_atid = rnd(64); s_aov = NOP'(rnd(16));
                for (int i = 0; i < NOP; i++) s_ar[i] = rnd(16);
            end
            if (rnd(4) == 0) begin
                s_wv = 1; s_wtid = rnd(64); s_wrv = NWR'(rnd(4));
                for (int i = 0; i < NWR; i++) s_wr[i] = rnd(16);
            end
            if (n == 2000) cur_req = "R4";
            step();
        end
        idle(40);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog %s: actual %0d expected %0d", cur_req, 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule